// File: doc/BRIEF.md
# Banked Priority Interrupt Controller

This block collects up to 32 interrupt lines into one bank. For each line it holds a mask bit, a priority, a sense mode and a routing choice. Among the unmasked pending lines it picks a winner and drives one of two request outputs: a normal request or a fast request. Software reads the winning line number from a status register. It writes a control register to acknowledge that request. The next request can only be raised after the acknowledge.

Two banks are meant to be cascaded. A second-level bank is built with fast routing disabled, and its normal request output feeds one line of the first-level bank. Every second-level interrupt is then gated by the mask bit of that one first-level line. A software test register can raise any line without any external input.

All registers sit on a simple single-cycle port. A write takes effect at the clock edge. Read data is a combinational function of the address.

Top module: `bank_prio_intc`

## Requirements
- R1: After reset the mask register (offset 0x00) reads all ones, the test register (0x10) reads 0, the status register (0x0C) reads 0, every line-configuration register reads 0, and both request outputs are low.
- R2: Writing the mask register sets it to the written value, where 1 masks a line and 0 unmasks it. A masked line never raises a request output, but it still shows in the pending register (0x04).
- R3: Among unmasked pending candidates of one class, the line with the numerically lowest priority wins, and a tie goes to the lower line number. Status bits 4:0 give the normal-request winner and bit 7 its active flag. Status bits 12:8 give the fast-request winner and bit 15 its active flag.
- R4: Once raised, a request output stays high and its reported winner stays unchanged until an acknowledge. The acknowledge is a write to the control register (0x08), where bit 0 acknowledges the normal request, bit 1 the fast request, and the value 3 both.
- R5: After an acknowledge, the request output is low on the next cycle and stays low for at least one cycle before it can be raised again.
- R6: Line n has a configuration register at byte offset 0x80 + 4*n. Bit 0 routes the line to the fast request, bit 1 selects edge sensing (1) or level sensing (0), and bits 6:2 hold the priority. Written bits above bit 6 are ignored and read back as 0.
- R7: A line whose routing bit is set competes only for the fast request output. In a bank built without fast routing, the routing bit is forced to 0 on write and reads back 0, and the fast request output never rises.
- R8: An edge-sensed line latches a rising input into its pending bit and holds it after the input falls, until that line is acknowledged as the current winner. A level-sensed pending bit follows the input.
- R9: Each set bit of the test register acts as a raised input on its line. Writing 0 to the test register removes every test source.
- R10: When a second-level bank's normal request drives line 0 of a first-level bank, that line shows pending while it is masked. Unmasking it lets the second-level interrupt raise the first-level normal request with winner 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | N_LINES | Interrupt input lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The assertions check, on every cycle, the hold-until-acknowledge rule for the normal request, the forced low cycle after each acknowledge of either class, that a newly raised normal request never names a line that was masked, and that a bank without fast routing never raises its fast output. The bench scenarios cover the rest:
- the priority order and the tie-break by line number;
- edge latching against level following;
- the field layout of the line registers and the forcing of the routing bit in a second-level bank;
- the test register;
- the two-bank cascade through line 0.

// File: rtl/bpic_pkg.sv
package bpic_pkg;

  localparam int PRIO_W   = 5;
  localparam int CFG_W    = PRIO_W + 2;
  localparam int OFS_MASK = 'h00;
  localparam int OFS_PEND = 'h04;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_TEST = 'h10;
  localparam int OFS_CFG  = 'h80;

  // bit 0 routing, bit 1 sense, bits 6:2 priority
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_sense;
    logic              to_fiq;
  } line_cfg_t;

  typedef enum logic [1:0] {GS_IDLE, GS_HOLD, GS_GAP} gate_st_e;

  function automatic line_cfg_t cfg_from_word(logic [CFG_W-1:0] w, bit fiq_ok);
    line_cfg_t c;
    c.prio       = w[CFG_W-1:2];
    c.edge_sense = w[1];
    c.to_fiq     = fiq_ok ? w[0] : 1'b0;
    return c;
  endfunction

  function automatic logic prio_wins(logic [PRIO_W-1:0] cand, logic [PRIO_W-1:0] best,
                                     logic have_best);
    return !have_best || (cand < best);
  endfunction

endpackage

// File: rtl/bpic_regs.sv
module bpic_regs
  import bpic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit FIQ_OK  = 1'b1,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [N_LINES-1:0]    pend,
  input  logic [DATA_W-1:0]     stat_word,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [N_LINES-1:0]    mask_q,
  output logic [N_LINES-1:0]    test_q,
  output line_cfg_t             cfg_q [N_LINES],
  output logic                  ack_irq,
  output logic                  ack_fiq
);

  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;
  logic              wr_mask, wr_test, wr_ctrl;

  assign cfg_off = bus_addr - ADDR_W'(OFS_CFG);
  assign cfg_hit = (bus_addr >= ADDR_W'(OFS_CFG)) && (cfg_off[1:0] == 2'b00) &&
                   ((cfg_off >> 2) < ADDR_W'(N_LINES));
  assign cfg_idx = cfg_off[IDX_W+1:2];

  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_test = bus_wr && (bus_addr == ADDR_W'(OFS_TEST));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign ack_irq = wr_ctrl && bus_wdata[0];
  assign ack_fiq = wr_ctrl && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      test_q <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[N_LINES-1:0];
      if (wr_test) test_q <= bus_wdata[N_LINES-1:0];
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (bus_wr && cfg_hit && (cfg_idx == IDX_W'(i))) begin
        cfg_q[i] <= cfg_from_word(bus_wdata[CFG_W-1:0], FIQ_OK);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      bus_rdata = DATA_W'(cfg_q[cfg_idx]);
    end else begin
      case (int'(bus_addr))
        OFS_MASK: bus_rdata = DATA_W'(mask_q);
        OFS_PEND: bus_rdata = DATA_W'(pend);
        OFS_STAT: bus_rdata = stat_word;
        OFS_TEST: bus_rdata = DATA_W'(test_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/bpic_sense.sv
module bpic_sense #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw,
  input  logic [N_LINES-1:0] edge_sel,
  input  logic [N_LINES-1:0] clr,
  output logic [N_LINES-1:0] rise_det,
  output logic [N_LINES-1:0] pend
);

  logic [N_LINES-1:0] raw_q;
  logic [N_LINES-1:0] edge_lat;

  assign rise_det = raw & ~raw_q;
  assign pend     = (edge_sel & edge_lat) | (~edge_sel & raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= '0;
      edge_lat <= '0;
    end else begin
      raw_q    <= raw;
      // a fresh rising edge outweighs a clear in the same cycle
      edge_lat <= edge_sel & (rise_det | (edge_lat & ~clr));
    end
  end

endmodule

// File: rtl/bpic_arb.sv
module bpic_arb
  import bpic_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]            cand,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
  output logic                          win_any,
  output logic [IDX_W-1:0]              win_idx
);

  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: equal priority keeps the lower index
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    best_p  = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (cand[i] && prio_wins(prio[i], best_p, win_any)) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
        best_p  = prio[i];
      end
    end
  end

endmodule

// File: rtl/bpic_gate.sv
module bpic_gate
  import bpic_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_any,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             ack,
  output logic             req_out,
  output logic [IDX_W-1:0] cur,
  output logic             take
);

  gate_st_e st;

  assign req_out = (st == GS_HOLD);
  assign take    = ack && (st == GS_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= GS_IDLE;
      cur <= '0;
    end else begin
      unique case (st)
        GS_IDLE: if (win_any) begin
          st  <= GS_HOLD;
          cur <= win_idx;
        end
        GS_HOLD: if (ack) st <= GS_GAP;
        GS_GAP:  st <= GS_IDLE;
        default: st <= GS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bank_prio_intc.sv
module bank_prio_intc
  import bpic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit FIQ_OK  = 1'b1,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out,
  output logic               fiq_out
);

  logic [N_LINES-1:0]             mask_q, test_q, pend, rise_det, active;
  logic [N_LINES-1:0]             edge_sel, fiq_sel, clr;
  logic [N_LINES-1:0][PRIO_W-1:0] prio_v;
  line_cfg_t                      cfg_q [N_LINES];
  logic                           ack_irq, ack_fiq;
  logic                           irq_any, fiq_any, irq_take, fiq_take;
  logic [IDX_W-1:0]               irq_win, fiq_win, cur_irq, cur_fiq;
  logic [DATA_W-1:0]              stat_word;

  for (genvar i = 0; i < N_LINES; i++) begin : g_unpack
    assign edge_sel[i] = cfg_q[i].edge_sense;
    assign fiq_sel[i]  = cfg_q[i].to_fiq;
    assign prio_v[i]   = cfg_q[i].prio;
  end

  assign active = pend & ~mask_q;
  assign clr    = (irq_take ? (N_LINES'(1) << cur_irq) : '0) |
                  (fiq_take ? (N_LINES'(1) << cur_fiq) : '0);

  always_comb begin
    stat_word              = '0;
    stat_word[IDX_W-1:0]   = cur_irq;
    stat_word[7]           = irq_out;
    stat_word[8+:IDX_W]    = cur_fiq;
    stat_word[15]          = fiq_out;
  end

  bpic_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIQ_OK(FIQ_OK)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend(pend), .stat_word(stat_word), .bus_rdata(bus_rdata), .mask_q(mask_q),
    .test_q(test_q), .cfg_q(cfg_q), .ack_irq(ack_irq), .ack_fiq(ack_fiq)
  );

  bpic_sense #(.N_LINES(N_LINES)) sense_i (
    .clk(clk), .rst_n(rst_n), .raw(line_in | test_q), .edge_sel(edge_sel),
    .clr(clr), .rise_det(rise_det), .pend(pend)
  );

  bpic_arb #(.N_LINES(N_LINES)) irq_arb_i (
    .cand(active & ~fiq_sel), .prio(prio_v), .win_any(irq_any), .win_idx(irq_win)
  );

  bpic_gate #(.IDX_W(IDX_W)) irq_gate_i (
    .clk(clk), .rst_n(rst_n), .win_any(irq_any), .win_idx(irq_win), .ack(ack_irq),
    .req_out(irq_out), .cur(cur_irq), .take(irq_take)
  );

  if (FIQ_OK) begin : g_fiq
    bpic_arb #(.N_LINES(N_LINES)) fiq_arb_i (
      .cand(active & fiq_sel), .prio(prio_v), .win_any(fiq_any), .win_idx(fiq_win)
    );
    bpic_gate #(.IDX_W(IDX_W)) fiq_gate_i (
      .clk(clk), .rst_n(rst_n), .win_any(fiq_any), .win_idx(fiq_win), .ack(ack_fiq),
      .req_out(fiq_out), .cur(cur_fiq), .take(fiq_take)
    );
  end else begin : g_nofiq
    assign fiq_any  = 1'b0;
    assign fiq_win  = '0;
    assign fiq_out  = 1'b0;
    assign cur_fiq  = '0;
    assign fiq_take = 1'b0;
  end

endmodule

// File: rtl/bpic_chk.sv
module bpic_chk #(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 5,
  parameter bit FIQ_OK  = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic               fiq_out,
  input logic               irq_take,
  input logic               fiq_take,
  input logic [IDX_W-1:0]   cur_irq,
  input logic [N_LINES-1:0] mask_q
);

  logic [N_LINES-1:0] mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_d <= '1;
    else        mask_d <= mask_q;
  end

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !irq_take) |=> (irq_out && $stable(cur_irq)));

  a_r5_irq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_out);

  a_r5_fiq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_take |=> !fiq_out);

  a_r2_rise_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> !mask_d[cur_irq]);

  a_r7_no_fiq_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (FIQ_OK == 1'b0) |-> !fiq_out);

endmodule

bind bank_prio_intc bpic_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W), .FIQ_OK(FIQ_OK)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .fiq_out(fiq_out), .irq_take(irq_take),
  .fiq_take(fiq_take), .cur_irq(cur_irq), .mask_q(mask_q)
);

// File: tb/bank_prio_intc_tb_top.sv
module bank_prio_intc_tb_top;

  localparam int N = 32;
  localparam int AW = 8;
  localparam int DW = 32;
  // {write, addr, value (write data or expected read), requirement}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hFFFF_FFFF, 8'd1},  // R1 mask all ones
    {1'b0, 8'h10, 32'h0000_0000, 8'd1},  // R1 test clear
    {1'b0, 8'h0C, 32'h0000_0000, 8'd1},  // R1 status idle
    {1'b0, 8'h94, 32'h0000_0000, 8'd1},  // R1 line 5 config
    {1'b1, 8'h94, 32'h0000_007F, 8'd6},
    {1'b0, 8'h94, 32'h0000_007F, 8'd6},  // R6 full field readback
    {1'b1, 8'h94, 32'hFFFF_FF85, 8'd6},
    {1'b0, 8'h94, 32'h0000_0005, 8'd6},  // R6 upper bits dropped
    {1'b1, 8'h94, 32'h0000_0000, 8'd6},
    {1'b1, 8'h10, 32'h0000_0100, 8'd9},
    {1'b0, 8'h04, 32'h0000_0100, 8'd9},  // R9 test raises line 8
    {1'b0, 8'h0C, 32'h0000_0000, 8'd2},  // R2 masked: no request
    {1'b1, 8'h10, 32'h0000_0000, 8'd9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] l1_drv = '0, l2_in = '0, l1_lines;
  logic wr1 = 1'b0, wr2 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rd1, rd2, rv, mask_v;
  logic irq1, fiq1, irq2, fiq2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign l1_lines = {l1_drv[N-1:1], irq2};

  bank_prio_intc #(.N_LINES(N), .ADDR_W(AW), .DATA_W(DW), .FIQ_OK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(l1_lines), .bus_wr(wr1), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd1), .irq_out(irq1), .fiq_out(fiq1));

  bank_prio_intc #(.N_LINES(N), .ADDR_W(AW), .DATA_W(DW), .FIQ_OK(1'b0)) l2_i (
    .clk(clk), .rst_n(rst_n), .line_in(l2_in), .bus_wr(wr2), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd2), .irq_out(irq2), .fiq_out(fiq2));

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit second, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (second) wr2 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr1 = 1'b0; wr2 = 1'b0;
  endtask

  task automatic rd(input bit second, input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = second ? rd2 : rd1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk(!irq1 && !fiq1 && !irq2 && !fiq2, "R1 outputs low", {irq1, fiq1, irq2, fiq2}, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][48]) wr(1'b0, VEC[k][47:40], VEC[k][39:8]);
      else begin
        rd(1'b0, VEC[k][47:40], rv);
        chk(rv == VEC[k][39:8], $sformatf("R%0d vector %0d", VEC[k][7:0], k), rv, VEC[k][39:8]);
      end
    end
    rd(1'b0, 8'h04, rv);
    chk(rv == 0, "R9 test cleared by 0", rv, 0);

    // R3: priorities line3=10, line7=2, line9=2; line1 stays 0
    wr(1'b0, 8'h8C, 32'h28);
    wr(1'b0, 8'h9C, 32'h08);
    wr(1'b0, 8'hA4, 32'h08);
    mask_v = ~32'h0000_0288;
    wr(1'b0, 8'h00, mask_v);
    rd(1'b0, 8'h00, rv);
    chk(rv == mask_v, "R2 mask readback", rv, mask_v);
    l1_drv = 32'h0000_0288;
    wait_n(3);
    rd(1'b0, 8'h0C, rv);
    chk(irq1 && rv[7:0] == 8'h87, "R3 tie to lower line", rv, 32'h87);

    // R4: a better line arrives while held
    mask_v &= ~32'h2;
    wr(1'b0, 8'h00, mask_v);
    l1_drv |= 32'h2;
    wait_n(3);
    rd(1'b0, 8'h0C, rv);
    chk(irq1 && rv[4:0] == 5'd7, "R4 winner held", rv, 32'h87);
    wr(1'b0, 8'h08, 32'h1);
    chk(!irq1, "R5 low after ack", irq1, 0);
    wait_n(3);
    rd(1'b0, 8'h0C, rv);
    chk(irq1 && rv[4:0] == 5'd1, "R3 prio 0 wins after ack", rv, 32'h81);
    l1_drv = '0;
    wr(1'b0, 8'h08, 32'h1);
    wait_n(3);
    chk(!irq1, "R4 idle when nothing pending", irq1, 0);

    // R8: edge-sensed line 12, single-cycle pulse
    wr(1'b0, 8'hB0, 32'h02);
    mask_v &= ~32'h1000;
    wr(1'b0, 8'h00, mask_v);
    @(negedge clk); l1_drv[12] = 1'b1;
    @(negedge clk); l1_drv[12] = 1'b0;
    wait_n(2);
    rd(1'b0, 8'h04, rv);
    chk(rv[12] == 1'b1, "R8 edge latched", rv, 32'h1000);
    rd(1'b0, 8'h0C, rv);
    chk(irq1 && rv[4:0] == 5'd12, "R8 edge line requests", rv, 32'h8C);
    wr(1'b0, 8'h08, 32'h1);
    rd(1'b0, 8'h04, rv);
    chk(rv[12] == 1'b0, "R8 ack clears latch", rv, 0);
    wait_n(3);
    chk(!irq1, "R8 no request after clear", irq1, 0);

    // R8: level line 20 (masked) follows input
    l1_drv[20] = 1'b1;
    rd(1'b0, 8'h04, rv);
    chk(rv[20] == 1'b1, "R8 level high", rv, 32'h10_0000);
    l1_drv[20] = 1'b0;
    rd(1'b0, 8'h04, rv);
    chk(rv[20] == 1'b0, "R8 level follows low", rv, 0);
    chk(!irq1, "R2 masked level line silent", irq1, 0);

    // R7: line 15 routed to the fast request
    wr(1'b0, 8'hBC, 32'h01);
    mask_v &= ~32'h8000;
    wr(1'b0, 8'h00, mask_v);
    l1_drv[15] = 1'b1;
    wait_n(3);
    rd(1'b0, 8'h0C, rv);
    chk(fiq1 && !irq1 && rv[15:8] == 8'h8F, "R7 fast routing", rv, 32'h8F00);
    wr(1'b0, 8'h08, 32'h3);
    chk(!fiq1, "R4 ack value 3 drops fast", fiq1, 0);
    l1_drv[15] = 1'b0;

    // R7: second-level bank ignores the routing bit
    wr(1'b1, 8'h90, 32'h05);
    rd(1'b1, 8'h90, rv);
    chk(rv == 32'h04, "R7 routing forced 0", rv, 32'h04);
    l2_in[4] = 1'b1;
    wr(1'b1, 8'h00, ~32'h10);
    wait_n(3);
    chk(irq2 && !fiq2, "R7 l2 uses normal request", {irq2, fiq2}, 2'b10);

    // R10: cascade through line 0 of the first-level bank
    rd(1'b0, 8'h04, rv);
    chk(rv[0] == 1'b1 && !irq1, "R10 masked cascade pending", rv, 32'h1);
    mask_v &= ~32'h1;
    wr(1'b0, 8'h00, mask_v);
    wait_n(3);
    rd(1'b0, 8'h0C, rv);
    chk(irq1 && rv[4:0] == 5'd0, "R10 cascade raises l1", rv, 32'h80);

    done = 1'b1;
    finish_run();
  end

endmodule